// File: doc/BRIEF.md
# Way-Concatenating Configurable Cache

This block is an 8 KB read/write cache made of four physical ways of 64 sets each, with 32-byte lines and 32-bit addresses. Software picks one of three organisations at run time: four-way set-associative, two-way set-associative, or direct-mapped. The full capacity is usable in all three. When associativity drops, the ways are joined end to end, so each remaining logical way gets deeper. A two-bit mode register and address bits 12 and 11 feed a small decoder. The decoder enables only the tag arrays, data arrays and comparators of the physical ways that can hold the addressed line.

A processor presents one word request at a time. It holds the request until `req_ready` rises.
- A hit completes in the cycle it is presented.
- A miss stalls the processor for a fixed refill penalty. During the penalty the block fetches the whole line from the next level through a line-wide refill port, places the line in a victim way and then completes the access.
- Writes are allocating. Every completed write is also forwarded on a write-through port, so the next level stays current.
- Changing the mode flushes every line.

Top module: `wc_cache`

## Requirements
- R1: After reset the mode is four-way, every line is invalid, and `req_ready`, `fill_req`, `wt_valid` and `way_en` are all low.
- R2: `way_en` shows the ways enabled for a lookup. Mode 2'b11 (four-way) gives 4'b1111. Mode 2'b00 (direct-mapped) gives the one-hot of {a12,a11}. Modes 2'b01 and 2'b10 (two-way) give 4'b0101 when a11=0 and 4'b1010 when a11=1. `way_en` is 0 when no lookup is being made.
- R3: A read hit raises `req_ready` and `resp_hit` in the same cycle as the request. `resp_rdata` carries the addressed 32-bit word (word offset a4..a2).
- R4: A miss keeps `req_ready` low for exactly MISS_CYCLES+1 cycles (21 by default). `fill_req` is high for MISS_CYCLES of those cycles, with `fill_addr` holding the line-aligned address. Word i of the line is taken from `fill_line[32*i+31:32*i]`.
- R5: In every mode, four lines that share a10..a5 and differ only in {a12,a11} can all be resident at once.
- R6: In direct-mapped mode, two addresses that share a12..a5 and differ above a12 evict each other.
- R7: In four-way mode, four distinct tags in one set coexist. Filling a fifth tag, with no hits between the fills, evicts the first tag filled (tree pseudo-LRU with all bits cleared at reset).
- R8: In two-way mode, a line competes only with lines that share its a11. Of three tags filled in turn into one such pair, the third evicts the first.
- R9: A write hit updates the word, and later reads return the new value. A write miss refills the line, then writes the word. On the cycle a write completes, `wt_valid` is high with `wt_addr` and `wt_data` equal to the request.
- R10: A configuration write that changes the mode invalidates every line. Writing the mode that is already set leaves all contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_mode | input | 2 | New mode: 11 four-way, 01/10 two-way, 00 direct-mapped |
| req_valid | input | 1 | Request present; held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request completes this cycle |
| resp_hit | output | 1 | Lookup hit this cycle |
| resp_rdata | output | 32 | Read data, valid with `req_ready` |
| way_en | output | 4 | Physical ways enabled for the current lookup |
| fill_req | output | 1 | Refill in progress |
| fill_addr | output | 32 | Line-aligned refill address |
| fill_line | input | 256 | Line returned by the next level |
| wt_valid | output | 1 | Completed write forwarded |
| wt_addr | output | 32 | Address of the forwarded write |
| wt_data | output | 32 | Data of the forwarded write |

## Verification
Lookup results (`way_en`, `resp_hit`, `req_ready`, `resp_rdata`, `wt_*`) are combinational from the request and the stored state. The bench therefore drives each request just after a falling edge and samples 2 ns later, before the next rising edge. A miss is due 21 cycles later: one lookup cycle plus 20 refill cycles. The bench counts every sampled cycle with `req_ready` low and compares the count with 21 for a miss and 0 for a hit. Alongside this count it tallies the cycles in which `fill_req` was high. Eviction and retention are judged from that same wait count on a later access. A mode write takes effect at the next edge, so the following request is the first one that sees the new organisation.

// File: rtl/wc_pkg.sv
package wc_pkg;
    localparam int ADDR_W     = 32;
    localparam int OFF_W      = 5;
    localparam int SET_W      = 6;
    localparam int NWAYS      = 4;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = ((1 << OFF_W) * 8) / WORD_W;
    localparam int LINE_W     = LINE_WORDS * WORD_W;
    localparam int WOFF_W     = $clog2(LINE_WORDS);
    localparam int WSEL_W     = $clog2(NWAYS);
    localparam int TAG_W      = ADDR_W - OFF_W - SET_W;
    localparam int NSETS      = 1 << SET_W;
    localparam int LADDR_W    = ADDR_W - OFF_W;

    typedef logic [1:0] mode_t;
    localparam mode_t MODE_DM = 2'b00;
    localparam mode_t MODE_4W = 2'b11;

    // {leaf for odd low way bit, leaf for even low way bit, root}
    typedef logic [2:0] plru_t;

    function automatic logic [WSEL_W-1:0] plru_victim(mode_t m, plru_t p, logic [WSEL_W-1:0] sel);
        logic v0;
        logic v1;
        if (m == MODE_DM) return sel;
        v0 = (m == MODE_4W) ? p[0] : sel[0];
        v1 = v0 ? p[2] : p[1];
        return {v1, v0};
    endfunction

    function automatic plru_t plru_touch(plru_t p, logic [WSEL_W-1:0] w);
        plru_t r;
        r = p;
        r[0] = ~w[0];
        if (w[0]) r[2] = ~w[1];
        else      r[1] = ~w[1];
        return r;
    endfunction
endpackage

// File: rtl/wc_way_decode.sv
module wc_way_decode
    import wc_pkg::*;
(
    input  mode_t             mode,
    input  logic [WSEL_W-1:0] sel,
    output logic [NWAYS-1:0]  en
);
    logic all_on;
    logic need_hi;

    assign all_on  = mode[0] & mode[1];
    assign need_hi = ~(mode[0] | mode[1]);

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        localparam logic [WSEL_W-1:0] WID = WSEL_W'(w);
        assign en[w] = (all_on | (sel[0] == WID[0])) & (~need_hi | (sel[1] == WID[1]));
    end
endmodule

// File: rtl/wc_tag_store.sv
module wc_tag_store
    import wc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [NWAYS-1:0]  lk_en,
    output logic [NWAYS-1:0]  hit_vec,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              flush
);
    typedef struct packed {
        logic [NWAYS-1:0][NSETS-1:0]            valid;
        logic [NWAYS-1:0][NSETS-1:0][TAG_W-1:0] tag;
    } tags_t;

    tags_t ts_d, ts_q;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign hit_vec[w] = lk_en[w] & ts_q.valid[w][lk_set] & (ts_q.tag[w][lk_set] == lk_tag);
    end

    always_comb begin
        ts_d = ts_q;
        if (flush) begin
            ts_d.valid = '0;
        end else if (wr_en) begin
            ts_d.valid[wr_way][wr_set] = 1'b1;
            ts_d.tag[wr_way][wr_set]   = wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R3
endmodule

// File: rtl/wc_plru.sv
module wc_plru
    import wc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch_en,
    input  logic [SET_W-1:0]  touch_set,
    input  logic [WSEL_W-1:0] touch_way,
    input  mode_t             mode,
    input  logic [SET_W-1:0]  vic_set,
    input  logic [WSEL_W-1:0] vic_sel,
    output logic [WSEL_W-1:0] victim
);
    typedef struct packed {
        logic [NSETS-1:0][2:0] bits;
    } plru_st_t;

    plru_st_t pl_d, pl_q;

    assign victim = plru_victim(mode, pl_q.bits[vic_set], vic_sel);

    always_comb begin
        pl_d = pl_q;
        if (touch_en) pl_d.bits[touch_set] = plru_touch(pl_q.bits[touch_set], touch_way);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pl_q <= '0;
        else        pl_q <= pl_d;
    end
endmodule

// File: rtl/wc_data_store.sv
module wc_data_store
    import wc_pkg::*;
(
    input  logic              clk,
    input  logic [WSEL_W-1:0] rd_way,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WOFF_W-1:0] rd_off,
    output logic [WORD_W-1:0] rd_data,
    input  logic              word_we,
    input  logic [WSEL_W-1:0] word_way,
    input  logic [SET_W-1:0]  word_set,
    input  logic [WOFF_W-1:0] word_off,
    input  logic [WORD_W-1:0] word_data,
    input  logic              line_we,
    input  logic [WSEL_W-1:0] line_way,
    input  logic [SET_W-1:0]  line_set,
    input  logic [LINE_W-1:0] line_data
);
    localparam int DEPTH = NWAYS * NSETS * LINE_WORDS;

    logic [WORD_W-1:0] mem [DEPTH];

    assign rd_data = mem[{rd_way, rd_set, rd_off}];

    always_ff @(posedge clk) begin
        if (line_we) begin
            for (int i = 0; i < LINE_WORDS; i++) begin
                mem[{line_way, line_set, WOFF_W'(i)}] <= line_data[i*WORD_W +: WORD_W];
            end
        end else if (word_we) begin
            mem[{word_way, word_set, word_off}] <= word_data;
        end
    end
endmodule

// File: rtl/wc_cache.sv
module wc_cache
    import wc_pkg::*;
#(
    parameter int MISS_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_hit,
    output logic [WORD_W-1:0] resp_rdata,
    output logic [NWAYS-1:0]  way_en,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_line,
    output logic              wt_valid,
    output logic [ADDR_W-1:0] wt_addr,
    output logic [WORD_W-1:0] wt_data
);
    localparam int CNT_W = $clog2(MISS_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MISS_CYCLES - 1);

    typedef enum logic {ST_LOOK, ST_FILL} st_e;

    typedef struct packed {
        st_e                st;
        logic [CNT_W-1:0]   cnt;
        mode_t              mode;
        logic [LADDR_W-1:0] line;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [SET_W-1:0]  lk_set, ms_set;
    logic [TAG_W-1:0]  lk_tag, ms_tag;
    logic [WSEL_W-1:0] lk_sel, ms_sel, hit_way, victim;
    logic [WOFF_W-1:0] lk_off;
    logic [NWAYS-1:0]  en, hit_vec, lk_en;
    logic              look, hit, mode_chg, fill_done;

    assign lk_set = req_addr[OFF_W +: SET_W];
    assign lk_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign lk_sel = req_addr[OFF_W+SET_W +: WSEL_W];
    assign lk_off = req_addr[OFF_W-1 -: WOFF_W];
    assign ms_set = c_q.line[0 +: SET_W];
    assign ms_tag = c_q.line[LADDR_W-1 -: TAG_W];
    assign ms_sel = c_q.line[SET_W +: WSEL_W];

    assign look  = (c_q.st == ST_LOOK) && req_valid;
    assign lk_en = look ? en : '0;

    wc_way_decode u_dec (
        .mode (c_q.mode),
        .sel  (lk_sel),
        .en   (en)
    );

    wc_tag_store u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_set  (lk_set),
        .lk_tag  (lk_tag),
        .lk_en   (lk_en),
        .hit_vec (hit_vec),
        .wr_en   (fill_done),
        .wr_way  (victim),
        .wr_set  (ms_set),
        .wr_tag  (ms_tag),
        .flush   (mode_chg)
    );

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (hit_vec[w]) hit_way = WSEL_W'(w);
        end
    end

    assign hit = |hit_vec;

    wc_plru u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (hit | fill_done),
        .touch_set (fill_done ? ms_set : lk_set),
        .touch_way (fill_done ? victim : hit_way),
        .mode      (c_q.mode),
        .vic_set   (ms_set),
        .vic_sel   (ms_sel),
        .victim    (victim)
    );

    wc_data_store u_data (
        .clk       (clk),
        .rd_way    (hit_way),
        .rd_set    (lk_set),
        .rd_off    (lk_off),
        .rd_data   (resp_rdata),
        .word_we   (hit & req_write),
        .word_way  (hit_way),
        .word_set  (lk_set),
        .word_off  (lk_off),
        .word_data (req_wdata),
        .line_we   (fill_done),
        .line_way  (victim),
        .line_set  (ms_set),
        .line_data (fill_line)
    );

    assign mode_chg  = cfg_we && (cfg_mode != c_q.mode);
    assign fill_done = (c_q.st == ST_FILL) && (c_q.cnt == CNT_LAST) && !mode_chg;

    always_comb begin
        c_d = c_q;
        if (mode_chg) begin
            c_d.mode = cfg_mode;
            c_d.st   = ST_LOOK;
            c_d.cnt  = '0;
        end else begin
            case (c_q.st)
                ST_LOOK: begin
                    if (req_valid && !hit) begin
                        c_d.st   = ST_FILL;
                        c_d.cnt  = '0;
                        c_d.line = req_addr[ADDR_W-1:OFF_W];
                    end
                end
                default: begin
                    if (c_q.cnt == CNT_LAST) c_d.st = ST_LOOK;
                    else                     c_d.cnt = c_q.cnt + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_LOOK, cnt: '0, mode: MODE_4W, line: '0};
        else        c_q <= c_d;
    end

    assign req_ready = hit;
    assign resp_hit  = hit;
    assign way_en    = lk_en;
    assign fill_req  = (c_q.st == ST_FILL);
    assign fill_addr = {c_q.line, {OFF_W{1'b0}}};
    assign wt_valid  = hit & req_write;
    assign wt_addr   = req_addr;
    assign wt_data   = req_wdata;

    AST_WAYEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        look |-> ($countones(way_en) == ((c_q.mode == MODE_4W) ? 4 :
                                          (c_q.mode == MODE_DM) ? 1 : 2))); // R2
    AST_FILL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !req_ready); // R4
    AST_FILL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && $past(fill_req) && !$past(mode_chg)) |-> $stable(fill_addr)); // R4
    AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !resp_hit); // R10
    AST_WT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wt_valid |-> (req_write && resp_hit && req_valid)); // R9
endmodule

// File: tb/wc_cache_tb.sv
module wc_cache_tb;
    localparam int MISS = 20;
    localparam int MISS_WAIT = MISS + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_mode = 2'b11;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready, resp_hit;
    logic [31:0]  resp_rdata;
    logic [3:0]   way_en;
    logic         fill_req;
    logic [31:0]  fill_addr;
    logic [255:0] fill_line;
    logic         wt_valid;
    logic [31:0]  wt_addr, wt_data;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    wc_cache #(.MISS_CYCLES(MISS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .resp_hit(resp_hit),
        .resp_rdata(resp_rdata), .way_en(way_en), .fill_req(fill_req),
        .fill_addr(fill_addr), .fill_line(fill_line), .wt_valid(wt_valid),
        .wt_addr(wt_addr), .wt_data(wt_data)
    );

    function automatic logic [31:0] memword(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] mk(input logic [18:0] up, input logic [1:0] sel,
                                       input logic [5:0] set, input logic [2:0] off);
        return {up, sel, set, off, 2'b00};
    endfunction

    always_comb begin
        for (int i = 0; i < 8; i++) fill_line[i*32 +: 32] = memword({fill_addr[31:5], 3'(i), 2'b00});
    end

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // One access; counts cycles with ready low and cycles with fill_req high.
    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                          output int waitc, output int fills, output logic [31:0] rd,
                          output logic fa_bad, output logic wt_ok);
        waitc = 0; fills = 0; rd = '0; fa_bad = 1'b0; wt_ok = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        for (int k = 0; k < 200; k++) begin
            #2;
            if (fill_req) begin
                fills++;
                if (fill_addr !== {a[31:5], 5'b0}) fa_bad = 1'b1;
            end
            if (req_ready) begin
                rd = resp_rdata;
                wt_ok = (wt_valid === wr) && (!wr || (wt_addr === a && wt_data === wd));
                break;
            end
            waitc++;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a, input int exp_wait,
                          input logic [31:0] exp_d);
        int w, f; logic [31:0] d; logic fb, wo;
        access(1'b0, a, '0, w, f, d, fb, wo);
        eq({req, " wait"}, 32'(w), 32'(exp_wait));
        eq({req, " data"}, d, exp_d);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        #2;
        eq("R1 ready idle", 32'(req_ready), 0);
        eq("R1 fill idle", 32'(fill_req), 0);
        eq("R1 wt idle", 32'(wt_valid), 0);
        eq("R1 way_en idle", 32'(way_en), 0);
    endtask

    task automatic t_miss_hit();
        int w, f; logic [31:0] d; logic fb, wo;
        logic [31:0] a = mk(19'h00011, 2'b00, 6'd1, 3'd2);
        access(1'b0, a, '0, w, f, d, fb, wo);
        eq("R1 R4 miss wait", 32'(w), MISS_WAIT);
        eq("R4 fill cycles", 32'(f), MISS);
        eq("R4 fill addr", 32'(fb), 0);
        eq("R4 fill data", d, memword(a));
        rd_chk("R3 hit other word", mk(19'h00011, 2'b00, 6'd1, 3'd7), 0,
               memword(mk(19'h00011, 2'b00, 6'd1, 3'd7)));
    endtask

    task automatic probe_en(input string req, input logic [31:0] a, input logic [3:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #2;
        eq(req, 32'(way_en), 32'(exp));
        #1;
        req_valid = 1'b0;
    endtask

    task automatic t_way_en();
        probe_en("R2 four-way", mk(19'h7, 2'b10, 6'd9, 3'd0), 4'b1111);
        set_mode(2'b00);
        probe_en("R2 direct sel2", mk(19'h7, 2'b10, 6'd9, 3'd0), 4'b0100);
        probe_en("R2 direct sel1", mk(19'h7, 2'b01, 6'd9, 3'd0), 4'b0010);
        set_mode(2'b01);
        probe_en("R2 two-way a11=0", mk(19'h7, 2'b10, 6'd9, 3'd0), 4'b0101);
        set_mode(2'b10);
        probe_en("R2 two-way a11=1", mk(19'h7, 2'b01, 6'd9, 3'd0), 4'b1010);
        @(negedge clk); #2;
        eq("R2 no request", 32'(way_en), 0);
        set_mode(2'b11);
    endtask

    task automatic t_four_way();
        for (int i = 0; i < 5; i++)
            rd_chk("R7 fill", mk(19'(8 + i), 2'b00, 6'd2, 3'd0), MISS_WAIT,
                   memword(mk(19'(8 + i), 2'b00, 6'd2, 3'd0)));
        for (int i = 1; i < 4; i++)
            rd_chk("R7 survivor hit", mk(19'(8 + i), 2'b00, 6'd2, 3'd0), 0,
                   memword(mk(19'(8 + i), 2'b00, 6'd2, 3'd0)));
        rd_chk("R7 first evicted", mk(19'd8, 2'b00, 6'd2, 3'd0), MISS_WAIT,
               memword(mk(19'd8, 2'b00, 6'd2, 3'd0)));
    endtask

    task automatic t_direct();
        set_mode(2'b00);
        for (int s = 0; s < 4; s++)
            rd_chk("R5 direct fill", mk(19'h21, 2'(s), 6'd3, 3'd1), MISS_WAIT,
                   memword(mk(19'h21, 2'(s), 6'd3, 3'd1)));
        for (int s = 0; s < 4; s++)
            rd_chk("R5 direct resident", mk(19'h21, 2'(s), 6'd3, 3'd1), 0,
                   memword(mk(19'h21, 2'(s), 6'd3, 3'd1)));
        rd_chk("R6 conflict fill", mk(19'h22, 2'b00, 6'd3, 3'd1), MISS_WAIT,
               memword(mk(19'h22, 2'b00, 6'd3, 3'd1)));
        rd_chk("R6 evicted", mk(19'h21, 2'b00, 6'd3, 3'd1), MISS_WAIT,
               memword(mk(19'h21, 2'b00, 6'd3, 3'd1)));
        rd_chk("R6 neighbour kept", mk(19'h21, 2'b01, 6'd3, 3'd1), 0,
               memword(mk(19'h21, 2'b01, 6'd3, 3'd1)));
    endtask

    task automatic t_two_way();
        set_mode(2'b01);
        rd_chk("R5 two-way odd pair", mk(19'h31, 2'b01, 6'd4, 3'd3), MISS_WAIT,
               memword(mk(19'h31, 2'b01, 6'd4, 3'd3)));
        for (int i = 0; i < 3; i++)
            rd_chk("R8 fill", mk(19'(40 + i), 2'b00, 6'd4, 3'd3), MISS_WAIT,
                   memword(mk(19'(40 + i), 2'b00, 6'd4, 3'd3)));
        rd_chk("R8 second kept", mk(19'd41, 2'b00, 6'd4, 3'd3), 0,
               memword(mk(19'd41, 2'b00, 6'd4, 3'd3)));
        rd_chk("R5 odd pair untouched", mk(19'h31, 2'b01, 6'd4, 3'd3), 0,
               memword(mk(19'h31, 2'b01, 6'd4, 3'd3)));
        rd_chk("R8 first evicted", mk(19'd40, 2'b00, 6'd4, 3'd3), MISS_WAIT,
               memword(mk(19'd40, 2'b00, 6'd4, 3'd3)));
        set_mode(2'b11);
    endtask

    task automatic t_write();
        int w, f; logic [31:0] d; logic fb, wo;
        logic [31:0] a = mk(19'h51, 2'b11, 6'd5, 3'd4);
        logic [31:0] b = mk(19'h51, 2'b11, 6'd5, 3'd6);
        access(1'b1, a, 32'hCAFE_0001, w, f, d, fb, wo);
        eq("R9 write miss wait", 32'(w), MISS_WAIT);
        eq("R9 write miss forward", 32'(wo), 1);
        rd_chk("R9 read after write miss", a, 0, 32'hCAFE_0001);
        rd_chk("R9 rest of line", b, 0, memword(b));
        access(1'b1, b, 32'hBEEF_0002, w, f, d, fb, wo);
        eq("R9 write hit wait", 32'(w), 0);
        eq("R9 write hit forward", 32'(wo), 1);
        rd_chk("R9 read after write hit", b, 0, 32'hBEEF_0002);
    endtask

    task automatic t_cfg();
        logic [31:0] a = mk(19'h61, 2'b00, 6'd6, 3'd0);
        rd_chk("R10 load", a, MISS_WAIT, memword(a));
        set_mode(2'b11);
        rd_chk("R10 same mode keeps", a, 0, memword(a));
        set_mode(2'b00);
        rd_chk("R10 change flushes", a, MISS_WAIT, memword(a));
        set_mode(2'b11);
        rd_chk("R10 change back flushes", a, MISS_WAIT, memword(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_hit();
        t_way_en();
        t_four_way();
        t_direct();
        t_two_way();
        t_write();
        t_cfg();
        finish_run();
    end
endmodule